// File: doc/BRIEF.md
# CAN Controller Command and Interrupt Unit

This unit is the host-facing control layer of a CAN controller. It sits between a byte-wide host register bus and two datapath neighbours: a frame transmitter, which it asks to send through a one-cycle request and which answers with a completion pulse, and a receive buffer, which reports single-cycle events when a frame starts arriving, is stored, is dropped for lack of room, or is rejected. The unit turns host writes to a command register into these actions. It keeps a status byte and a pending-interrupt byte. It drives one level-sensitive interrupt line, gated by a host-written enable byte.

The host learns what happened by reading the status byte and the interrupt byte. Reading the interrupt byte clears it. The receive-pending bit stays asserted after such a read while stored messages remain unreleased. An internal counter tracks unreleased messages. Each release command lowers it by one, and the receive status and interrupt bits drop only when it reaches zero. A transmission clears the buffer-free and complete status bits when it is requested. Those bits come back, together with a transmit interrupt, only when the transmitter reports completion.

Register map (byte addresses): 0x00 mode, 0x01 command, 0x02 status, 0x03 interrupt, 0x04 interrupt enable, 0x10 first transmit-buffer byte (write event only).

Top module: `can_cmd_irq_unit`

## Requirements
- R1: After synchronous reset the registers read as follows: mode 0x01, status 0x3C, interrupt 0x00, interrupt enable 0x00. The irq output is low and tx_req is low.
- R2: Writing command bit 0 while no transmission is outstanding has two effects. It raises tx_req for exactly one cycle, and it clears status bit 2 (buffer free) and status bit 3 (complete). Both bits stay clear until tx_done arrives.
- R3: tx_done while a transmission is outstanding sets status bits 3:2, clears status bit 5 (transmitting) and sets interrupt bit 1. A second request while one is outstanding produces no tx_req pulse, and tx_done with nothing outstanding has no effect.
- R4: A write to address 0x10 (first transmit-buffer byte) sets status bit 5.
- R5: An rx_stored pulse increments the unreleased-message count, which saturates at its maximum. It also sets status bit 0 and interrupt bit 0.
- R6: Command bit 2 decrements a nonzero message count. When the count reaches zero, status bit 0 and interrupt bit 0 clear. With a zero count the command changes nothing.
- R7: An rx_overrun pulse sets status bit 1 and interrupt bit 3. Command bit 3 clears both.
- R8: Status bit 4 (receiving) is set by rx_start and cleared by rx_stored, rx_overrun or rx_reject.
- R9: Reading address 0x03 returns the interrupt byte and then clears it. Bit 0 is set again in the same cycle when the message count is nonzero.
- R10: irq is high exactly when any bit of (interrupt enable AND interrupt pending) is set. It updates on the same clock edge as either register.
- R11: The command register reads 0x00 and unmapped addresses read 0x00. Writes to the status and interrupt registers change nothing.
- R12: A command write with several bits set applies all of them in that same cycle, in the order transmit, release, clear overrun. A hardware event arriving in the same cycle takes precedence over a clear.
- R13: A mode write stores only the low five bits of the written byte, and the stored value reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered, valid the cycle after bus_rd |
| tx_req | output | 1 | One-cycle request to the frame transmitter |
| tx_done | input | 1 | Transmission-finished pulse |
| rx_start | input | 1 | A frame has begun arriving |
| rx_stored | input | 1 | A frame was stored in the receive buffer |
| rx_overrun | input | 1 | A frame was lost for lack of buffer room |
| rx_reject | input | 1 | A frame was dropped by filtering |
| irq | output | 1 | Level interrupt, registered |

## Verification
The bench targets the read-to-clear edge. With two messages queued, a reader of the interrupt byte must still see bit 0 on the following read; a design that cleared unconditionally would lose the receive interrupt while frames wait. Release is driven to zero and then once more: a design that let the count wrap would show the buffer as full again. A repeated transmit request during a pending transmission must not pulse tx_req, and the completion bits must stay low until tx_done, so a design that completed instantly would show 0x3C early. Enable gating is checked by changing only the enable byte, and a combined command byte checks that all three actions land together.

// File: rtl/can_ci_pkg.sv
package can_ci_pkg;
  // register byte addresses
  localparam int A_MODE = 0;
  localparam int A_CMD  = 1;
  localparam int A_STAT = 2;
  localparam int A_INT  = 3;
  localparam int A_IEN  = 4;
  localparam int A_TXB0 = 16;

  // command bits
  localparam int C_TX   = 0;
  localparam int C_REL  = 2;
  localparam int C_CLRO = 3;

  // interrupt bits
  localparam int I_RX  = 0;
  localparam int I_TX  = 1;
  localparam int I_OVR = 3;

  localparam int MODE_BITS = 5;

  typedef struct packed {
    logic tx;
    logic rel;
    logic clro;
    logic wr_mode;
    logic wr_ien;
    logic wr_txb0;
    logic rd_int;
  } can_ci_cmd_t;
endpackage

// File: rtl/can_ci_cmd_dec.sv
module can_ci_cmd_dec
  import can_ci_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output can_ci_cmd_t       cmd
);
  logic hit_cmd;

  always_comb begin
    hit_cmd      = wr && (addr == ADDR_W'(A_CMD));
    cmd.tx       = hit_cmd && wdata[C_TX];
    cmd.rel      = hit_cmd && wdata[C_REL];
    cmd.clro     = hit_cmd && wdata[C_CLRO];
    cmd.wr_mode  = wr && (addr == ADDR_W'(A_MODE));
    cmd.wr_ien   = wr && (addr == ADDR_W'(A_IEN));
    cmd.wr_txb0  = wr && (addr == ADDR_W'(A_TXB0));
    cmd.rd_int   = rd && (addr == ADDR_W'(A_INT));
  end
endmodule

// File: rtl/can_ci_tx_ctrl.sv
module can_ci_tx_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic cmd_tx,
  input  logic txb0_wr,
  input  logic tx_done,
  output logic tx_req,
  output logic busy,
  output logic buf_free,
  output logic complete,
  output logic sending,
  output logic done_evt
);
  logic start;

  assign start    = cmd_tx && !busy;
  assign done_evt = busy && tx_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_req   <= 1'b0;
      busy     <= 1'b0;
      buf_free <= 1'b1;
      complete <= 1'b1;
      sending  <= 1'b1;
    end else begin
      tx_req <= start;
      if (start) begin
        busy     <= 1'b1;
        buf_free <= 1'b0;
        complete <= 1'b0;
      end else if (done_evt) begin
        busy     <= 1'b0;
        buf_free <= 1'b1;
        complete <= 1'b1;
      end
      if (txb0_wr) begin
        sending <= 1'b1;
      end else if (done_evt) begin
        sending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/can_ci_rx_ctrl.sv
module can_ci_rx_ctrl #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_start,
  input  logic             rx_stored,
  input  logic             rx_overrun,
  input  logic             rx_reject,
  input  logic             cmd_rel,
  input  logic             cmd_clro,
  output logic [CNT_W-1:0] cnt,
  output logic             cnt_nz,
  output logic             ovr,
  output logic             receiving,
  output logic             rel_zero
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             inc, dec;
  logic [CNT_W-1:0] cnt_next;

  always_comb begin
    inc      = rx_stored && (cnt != CNT_MAX);
    dec      = cmd_rel && (cnt != '0);
    cnt_next = cnt + CNT_W'(inc) - CNT_W'(dec);
    rel_zero = dec && (cnt_next == '0);
  end

  assign cnt_nz = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      ovr       <= 1'b0;
      receiving <= 1'b1;
    end else begin
      cnt <= cnt_next;
      if (rx_overrun) begin
        ovr <= 1'b1;
      end else if (cmd_clro) begin
        ovr <= 1'b0;
      end
      if (rx_start) begin
        receiving <= 1'b1;
      end else if (rx_stored || rx_overrun || rx_reject) begin
        receiving <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/can_cmd_irq_unit.sv
module can_cmd_irq_unit
  import can_ci_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tx_req,
  input  logic              tx_done,
  input  logic              rx_start,
  input  logic              rx_stored,
  input  logic              rx_overrun,
  input  logic              rx_reject,
  output logic              irq
);
  localparam logic [DATA_W-1:0] MODE_RST  = DATA_W'(1);
  localparam logic [DATA_W-1:0] MODE_MASK = DATA_W'((1 << MODE_BITS) - 1);

  can_ci_cmd_t      cmd;
  logic             busy, buf_free, complete, sending, done_evt;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_nz, ovr, receiving, rel_zero;
  logic [DATA_W-1:0] mode_q, ien_q, int_q, int_n, ien_n, st;

  can_ci_cmd_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .wr(bus_wr), .rd(bus_rd), .addr(bus_addr), .wdata(bus_wdata), .cmd(cmd)
  );

  can_ci_tx_ctrl u_tx (
    .clk(clk), .rst(rst), .cmd_tx(cmd.tx), .txb0_wr(cmd.wr_txb0),
    .tx_done(tx_done), .tx_req(tx_req), .busy(busy), .buf_free(buf_free),
    .complete(complete), .sending(sending), .done_evt(done_evt)
  );

  can_ci_rx_ctrl #(.CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst(rst), .rx_start(rx_start), .rx_stored(rx_stored),
    .rx_overrun(rx_overrun), .rx_reject(rx_reject), .cmd_rel(cmd.rel),
    .cmd_clro(cmd.clro), .cnt(cnt_q), .cnt_nz(cnt_nz), .ovr(ovr),
    .receiving(receiving), .rel_zero(rel_zero)
  );

  // status byte: 5 sending, 4 receiving, 3 complete, 2 buffer free, 1 overrun, 0 rx full
  assign st = DATA_W'({sending, receiving, complete, buf_free, ovr, cnt_nz});

  // pending interrupts: read-clear first, then command clears, then events set
  always_comb begin
    int_n = int_q;
    if (cmd.rd_int) begin
      int_n        = '0;
      int_n[I_RX]  = cnt_nz;
    end
    if (rel_zero)   int_n[I_RX]  = 1'b0;
    if (cmd.clro)   int_n[I_OVR] = 1'b0;
    if (done_evt)   int_n[I_TX]  = 1'b1;
    if (rx_stored)  int_n[I_RX]  = 1'b1;
    if (rx_overrun) int_n[I_OVR] = 1'b1;
    ien_n = cmd.wr_ien ? bus_wdata : ien_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MODE_RST;
      ien_q     <= '0;
      int_q     <= '0;
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      int_q <= int_n;
      ien_q <= ien_n;
      irq   <= |(ien_n & int_n);
      if (cmd.wr_mode) mode_q <= bus_wdata & MODE_MASK;
      if (bus_rd) begin
        case (bus_addr)
          ADDR_W'(A_MODE): bus_rdata <= mode_q;
          ADDR_W'(A_STAT): bus_rdata <= st;
          ADDR_W'(A_INT):  bus_rdata <= int_q;
          ADDR_W'(A_IEN):  bus_rdata <= ien_q;
          default:         bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/can_cmd_irq_chk.sv
module can_cmd_irq_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_req,
  input logic              tx_done,
  input logic              busy,
  input logic              irq,
  input logic              rx_overrun,
  input logic              rx_stored,
  input logic              cmd_rel,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [DATA_W-1:0] st,
  input logic [DATA_W-1:0] int_q,
  input logic [DATA_W-1:0] ien_q
);
  p_txreq_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    tx_req |=> !tx_req) else $error("tx_req longer than one cycle");

  p_txreq_bits_r2: assert property (@(posedge clk) disable iff (rst)
    tx_req |-> (st[3:2] == 2'b00)) else $error("completion bits set during request");

  p_done_sets_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && tx_done) |=> (st[3:2] == 2'b11 && int_q[1] && !st[5]))
    else $error("completion not recorded");

  p_release_last_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_rel && cnt_q == CNT_W'(1) && !rx_stored) |=> (!int_q[0] && !st[0]))
    else $error("last release left receive flags");

  p_overrun_r7: assert property (@(posedge clk) disable iff (rst)
    rx_overrun |=> (st[1] && int_q[3])) else $error("overrun not flagged");

  p_irq_level_r10: assert property (@(posedge clk) disable iff (rst)
    irq == |(ien_q & int_q)) else $error("irq mismatch");
endmodule

bind can_cmd_irq_unit can_cmd_irq_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tx_req(tx_req), .tx_done(tx_done), .busy(busy),
  .irq(irq), .rx_overrun(rx_overrun), .rx_stored(rx_stored), .cmd_rel(cmd.rel),
  .cnt_q(cnt_q), .st(st), .int_q(int_q), .ien_q(ien_q)
);

// File: tb/can_cmd_irq_unit_tb_top.sv
module can_cmd_irq_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_MAX    = 63;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       tx_req, irq;
  logic       tx_done = 1'b0, rx_start = 1'b0, rx_stored = 1'b0;
  logic       rx_overrun = 1'b0, rx_reject = 1'b0;

  int checks = 0, errors = 0;
  string cur_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  can_cmd_irq_unit dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_req(tx_req),
    .tx_done(tx_done), .rx_start(rx_start), .rx_stored(rx_stored),
    .rx_overrun(rx_overrun), .rx_reject(rx_reject), .irq(irq)
  );

  // behavioural reference model
  int  m_mode, m_ien, m_int, m_rdata, m_cnt;
  bit  m_irq, m_txreq, m_busy, m_tbs, m_tcs, m_txing, m_rxing, m_ovr;
  bit  started = 0;

  function automatic int m_status();
    return (int'(m_txing) << 5) | (int'(m_rxing) << 4) | (int'(m_tcs) << 3) |
           (int'(m_tbs) << 2) | (int'(m_ovr) << 1) | int'(m_cnt != 0);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 1; m_ien = 0; m_int = 0; m_rdata = 0; m_cnt = 0;
      m_irq = 0; m_txreq = 0; m_busy = 0; m_tbs = 1; m_tcs = 1;
      m_txing = 1; m_rxing = 1; m_ovr = 0;
      started = 1;
    end else begin
      bit c_tx, c_rel, c_clr, done, relz;
      int i, ncnt;
      c_tx  = bus_wr && bus_addr == 1 && bus_wdata[0];
      c_rel = bus_wr && bus_addr == 1 && bus_wdata[2];
      c_clr = bus_wr && bus_addr == 1 && bus_wdata[3];
      if (bus_rd) begin
        case (bus_addr)
          0: m_rdata = m_mode;
          2: m_rdata = m_status();
          3: m_rdata = m_int;
          4: m_rdata = m_ien;
          default: m_rdata = 0;
        endcase
      end
      i = m_int;
      if (bus_rd && bus_addr == 3) i = (m_cnt != 0) ? 1 : 0;
      done = m_busy && tx_done;
      ncnt = m_cnt + ((rx_stored && m_cnt < CNT_MAX) ? 1 : 0) - ((c_rel && m_cnt > 0) ? 1 : 0);
      relz = c_rel && m_cnt > 0 && ncnt == 0;
      m_txreq = c_tx && !m_busy;
      if (c_tx && !m_busy) begin
        m_busy = 1; m_tbs = 0; m_tcs = 0;
      end else if (done) begin
        m_busy = 0; m_tbs = 1; m_tcs = 1; m_txing = 0;
      end
      if (bus_wr && bus_addr == 16) m_txing = 1;
      if (relz) i = i & ~1;
      if (c_clr) i = i & ~8;
      if (done) i = i | 2;
      if (rx_stored) i = i | 1;
      if (rx_overrun) i = i | 8;
      m_int = i;
      m_cnt = ncnt;
      if (rx_overrun) m_ovr = 1; else if (c_clr) m_ovr = 0;
      if (rx_start) m_rxing = 1;
      else if (rx_stored || rx_overrun || rx_reject) m_rxing = 0;
      if (bus_wr && bus_addr == 4) m_ien = int'(bus_wdata);
      if (bus_wr && bus_addr == 0) m_mode = int'(bus_wdata) & 8'h1F;
      m_irq = (m_ien & m_int) != 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every clock
  always @(negedge clk) begin
    if (started) begin
      chk({cur_tag, " R10 irq"}, int'(irq), int'(m_irq));
      chk({cur_tag, " R2 tx_req"}, int'(tx_req), int'(m_txreq));
      chk({cur_tag, " rdata"}, int'(bus_rdata), m_rdata);
    end
  end

  task automatic wr(input int a, input int d);
    bus_addr = 5'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    bus_addr = 5'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(tag, int'(bus_rdata), exp);
  endtask

  task automatic pulse(input int which);
    case (which)
      0: tx_done = 1'b1;
      1: rx_start = 1'b1;
      2: rx_stored = 1'b1;
      3: rx_overrun = 1'b1;
      default: rx_reject = 1'b1;
    endcase
    @(negedge clk);
    tx_done = 0; rx_start = 0; rx_stored = 0; rx_overrun = 0; rx_reject = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    cur_tag = "R1";
    chk("R1 irq", int'(irq), 0);
    chk("R1 tx_req", int'(tx_req), 0);
    rd(0, 8'h01, "R1 mode");
    rd(2, 8'h3C, "R1 status");
    rd(3, 8'h00, "R1 int");
    rd(4, 8'h00, "R1 ien");

    cur_tag = "R11";
    rd(1, 8'h00, "R11 cmd read");
    wr(2, 8'hFF);
    rd(2, 8'h3C, "R11 status write ignored");
    wr(3, 8'hFF);
    rd(3, 8'h00, "R11 int write ignored");
    chk("R11 irq after int write", int'(irq), 0);
    rd(7, 8'h00, "R11 unmapped");

    cur_tag = "R13";
    wr(0, 8'hFE);
    rd(0, 8'h1E, "R13 mode mask");

    cur_tag = "R2";
    wr(4, 8'hFF);
    wr(1, 8'h01);
    chk("R2 tx_req pulse", int'(tx_req), 1);
    rd(2, 8'h30, "R2 status while pending");
    chk("R2 tx_req single", int'(tx_req), 0);
    cur_tag = "R3";
    wr(1, 8'h01);
    chk("R3 no second request", int'(tx_req), 0);
    pulse(0);
    chk("R3 irq after done", int'(irq), 1);
    rd(2, 8'h1C, "R3 status after done");
    rd(3, 8'h02, "R3 int tx bit");
    rd(3, 8'h00, "R9 int cleared");
    pulse(0);
    rd(2, 8'h1C, "R3 stray done ignored");

    cur_tag = "R4";
    wr(16, 8'h55);
    rd(2, 8'h3C, "R4 sending bit");

    cur_tag = "R8";
    pulse(4);
    rd(2, 8'h2C, "R8 reject clears receiving");
    pulse(1);
    rd(2, 8'h3C, "R8 start sets receiving");

    cur_tag = "R5";
    pulse(2);
    rd(2, 8'h2D, "R5 stored status");
    chk("R5 irq", int'(irq), 1);
    pulse(2);
    cur_tag = "R9";
    rd(3, 8'h01, "R9 first read");
    rd(3, 8'h01, "R9 bit0 reasserted");

    cur_tag = "R6";
    wr(1, 8'h04);
    rd(2, 8'h2D, "R6 one message left");
    rd(3, 8'h01, "R6 int still set");
    wr(1, 8'h04);
    rd(2, 8'h2C, "R6 count zero status");
    rd(3, 8'h00, "R6 int cleared");
    chk("R6 irq low", int'(irq), 0);
    wr(1, 8'h04);
    rd(2, 8'h2C, "R6 release at zero ignored");

    cur_tag = "R7";
    pulse(3);
    rd(2, 8'h2E, "R7 overrun status");
    chk("R7 irq", int'(irq), 1);
    cur_tag = "R10";
    wr(4, 8'h00);
    chk("R10 masked", int'(irq), 0);
    wr(4, 8'h08);
    chk("R10 enabled", int'(irq), 1);
    cur_tag = "R7";
    wr(1, 8'h08);
    chk("R7 irq after clear", int'(irq), 0);
    rd(2, 8'h2C, "R7 clear status");
    rd(3, 8'h00, "R7 clear int");

    cur_tag = "R12";
    pulse(2);
    pulse(3);
    rd(2, 8'h2F, "R12 setup status");
    wr(1, 8'h0D);
    chk("R12 tx_req", int'(tx_req), 1);
    rd(2, 8'h20, "R12 combined command");
    pulse(0);
    rd(2, 8'h0C, "R12 after done");
    rd(3, 8'h02, "R12 int");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule